// File: doc/BRIEF.md
# Entropy Seed Register

This block is a polled entropy source that a processor reaches through a CSR-style port. The processor issues one combined read-and-write access with a write value of zero. One cycle later it gets a single 32-bit word. That word says which phase the source is in and, when 16 fresh bits are ready, carries them. The noise comes from a free-running linear feedback shift register that stands in for a physical noise cell. An accumulator gathers one bit of it per cycle.

After reset the source runs a self-test phase of fixed length and then starts collecting. A read that returns entropy empties the accumulator, so the same bits are never handed out twice. A privilege enable decides whether an access is allowed. A refused access raises an illegal-access pulse in place of data. A test input drives the source into a permanent failure phase that only reset leaves.

Top module: `seed_csr_top`

## Requirements
- R1: Bits 31:30 of every returned word carry the status: 00 self-test, 01 waiting, 10 sixteen entropy bits present, 11 unrecoverable failure. Bits 29:16 always read as zero.
- R2: After reset the status is 00 for exactly BIST_CYCLES clock edges and then becomes 01. No entropy is gathered during self-test.
- R3: Outside self-test and failure, the accumulator shifts one noise bit per cycle into bit 0 while it holds fewer than 16 bits. The status turns 10 on the edge that brings in the 16th bit.
- R4: The noise bit is bit 15 of a 16-bit register. The register loads LFSR_SEED at reset and on every edge shifts left, taking in the XOR of its bits 15, 13, 12 and 10.
- R5: With status 10, bits 15:0 hold the gathered bits, the oldest in bit 15. With any other status, bits 15:0 read as zero.
- R6: An access that returns status 10 empties the accumulator. Following reads report 01 until 16 new bits have been gathered, starting on the edge after the consuming access.
- R7: An access sampled high on a clock edge produces a one-cycle response pulse at the next output update. Its word reflects the state from before that edge. With no access the response outputs stay low and zero.
- R8: An access made while the privilege enable is low returns a one-cycle illegal pulse with an all-zero word and consumes nothing.
- R9: A high force-failure input moves the status to 11 on that edge. The status stays 11, with bits 15:0 zero, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Read-and-write access strobe (write value zero) |
| allow_i | input | 1 | Privilege enable for the access |
| fail_force_i | input | 1 | Test input forcing the failure phase |
| rvalid_o | output | 1 | Response pulse, one cycle after an access |
| illegal_o | output | 1 | Refused-access pulse |
| rdata_o | output | 32 | Status and entropy word |

## Verification
The bench builds the block with BIST_CYCLES set to 12 and the default seed. This keeps the self-test phase short, so many random accesses land during self-test, waiting and ready within one run. It also puts the self-test-to-waiting boundary within reach of a directed read on every cycle. A cycle model of the shift register and accumulator in the bench predicts every returned entropy value. It also covers consumption on back-to-back reads, refused reads that leave a full buffer in place, and a forced failure that survives until a second reset.

// File: rtl/seed_csr_pkg.sv
package seed_csr_pkg;
  typedef enum logic [1:0] {
    OPST_BIST = 2'b00,
    OPST_WAIT = 2'b01,
    OPST_ES16 = 2'b10,
    OPST_DEAD = 2'b11
  } opst_e;

  typedef enum logic [1:0] {
    PH_BIST = 2'd0,
    PH_RUN  = 2'd1,
    PH_DEAD = 2'd2
  } phase_e;

  localparam int unsigned ENT_W  = 16;
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int unsigned     W    = 16,
  parameter logic [W-1:0]    SEED = 16'hACE1,
  parameter logic [W-1:0]    TAPS = 16'hB400
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign bit_o = state_q[W-1];
endmodule

// File: rtl/entropy_acc.sv
module entropy_acc #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         noise_i,
  input  logic         consume_i,
  output logic         full_o,
  output logic [N-1:0] data_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [CW-1:0] cnt_q;
  logic [N-1:0]  acc_q;

  assign full_o = (cnt_q == CW'(N));
  assign data_o = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (consume_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (run_i && !full_o) begin
      acc_q <= {acc_q[N-2:0], noise_i};
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/seed_fsm.sv
module seed_fsm
  import seed_csr_pkg::*;
#(
  parameter int unsigned BIST_CYCLES = 64
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  fail_i,
  input  logic  full_i,
  output logic  run_o,
  output opst_e status_o
);
  localparam int unsigned TW = $clog2(BIST_CYCLES + 1);

  phase_e        ph_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_BIST;
      tcnt_q <= '0;
    end else if (fail_i) begin
      ph_q <= PH_DEAD;
    end else if (ph_q == PH_BIST) begin
      if (tcnt_q == TW'(BIST_CYCLES - 1)) ph_q <= PH_RUN;
      else                                 tcnt_q <= tcnt_q + TW'(1);
    end
  end

  assign run_o = (ph_q == PH_RUN);

  always_comb begin
    unique case (ph_q)
      PH_BIST: status_o = OPST_BIST;
      PH_RUN:  status_o = full_i ? OPST_ES16 : OPST_WAIT;
      default: status_o = OPST_DEAD;
    endcase
  end
endmodule

// File: rtl/seed_csr_top.sv
module seed_csr_top
  import seed_csr_pkg::*;
#(
  parameter int unsigned  BIST_CYCLES = 64,
  parameter logic [15:0]  LFSR_SEED   = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              allow_i,
  input  logic              fail_force_i,
  output logic              rvalid_o,
  output logic              illegal_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = WORD_W - 2 - ENT_W;

  logic             noise;
  logic             run;
  logic             full;
  logic             consume;
  logic [ENT_W-1:0] ent;
  opst_e            status;

  noise_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_noise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_o (noise)
  );

  entropy_acc #(.N(ENT_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .noise_i  (noise),
    .consume_i(consume),
    .full_o   (full),
    .data_o   (ent)
  );

  seed_fsm #(.BIST_CYCLES(BIST_CYCLES)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fail_i  (fail_force_i),
    .full_i  (full),
    .run_o   (run),
    .status_o(status)
  );

  assign consume = acc_i && allow_i && (status == OPST_ES16);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o  <= 1'b0;
      illegal_o <= 1'b0;
      rdata_o   <= '0;
    end else begin
      rvalid_o  <= acc_i;
      illegal_o <= acc_i && !allow_i;
      if (acc_i && allow_i)
        rdata_o <= {status, {PAD_W{1'b0}},
                    (status == OPST_ES16) ? ent : {ENT_W{1'b0}}};
      else
        rdata_o <= '0;
    end
  end
endmodule

// File: rtl/seed_csr_chk.sv
module seed_csr_chk
  import seed_csr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        acc_i,
  input logic        fail_force_i,
  input logic        rvalid_o,
  input logic        illegal_o,
  input logic [31:0] rdata_o,
  input opst_e       status,
  input logic        consume,
  input logic        full
);
  assert_pad_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> rdata_o[29:16] == 14'd0);

  assert_bist_no_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status == OPST_BIST && !fail_force_i) |=> status != OPST_ES16);

  assert_data_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rdata_o[31:30] != OPST_ES16) |-> rdata_o[15:0] == 16'd0);

  assert_consume_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume |=> !full);

  assert_resp_follows_acc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rvalid_o);

  assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (rvalid_o && rdata_o == 32'd0));

  assert_dead_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status == OPST_DEAD |=> status == OPST_DEAD);
endmodule

bind seed_csr_top seed_csr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_i       (acc_i),
  .fail_force_i(fail_force_i),
  .rvalid_o    (rvalid_o),
  .illegal_o   (illegal_o),
  .rdata_o     (rdata_o),
  .status      (status),
  .consume     (consume),
  .full        (full)
);

// File: tb/tb_seed_csr_top.sv
`timescale 1ns/1ps
module tb_seed_csr_top;
  localparam int unsigned BIST = 12;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic acc_i = 1'b0;
  logic allow_i = 1'b1;
  logic fail_force_i = 1'b0;
  logic rvalid_o, illegal_o;
  logic [31:0] rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  seed_csr_top #(.BIST_CYCLES(BIST), .LFSR_SEED(SEED)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .allow_i(allow_i),
    .fail_force_i(fail_force_i), .rvalid_o(rvalid_o), .illegal_o(illegal_o),
    .rdata_o(rdata_o)
  );

  // bench model built from the requirements (0 self-test, 1 run, 2 dead)
  logic [15:0] m_lfsr, m_acc;
  int          m_cnt, m_tcnt, m_ph;
  logic        e_v, e_ill;
  logic [31:0] e_d;

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [1:0] m_status(input int ph, input int cnt);
    if (ph == 0) return 2'b00;
    if (ph == 2) return 2'b11;
    return (cnt == 16) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [31:0] m_word(input logic [1:0] st, input logic [15:0] a);
    return {st, 14'd0, (st == 2'b10) ? a : 16'd0};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_lfsr <= SEED; m_acc <= '0; m_cnt <= 0; m_tcnt <= 0; m_ph <= 0;
      e_v <= 1'b0; e_ill <= 1'b0; e_d <= '0;
    end else begin
      e_v   <= acc_i;
      e_ill <= acc_i && !allow_i;
      e_d   <= (acc_i && allow_i) ? m_word(m_status(m_ph, m_cnt), m_acc) : 32'd0;
      m_lfsr <= lfsr_next(m_lfsr);
      if (acc_i && allow_i && m_status(m_ph, m_cnt) == 2'b10) begin
        m_cnt <= 0; m_acc <= '0;
      end else if (m_ph == 1 && m_cnt < 16) begin
        m_acc <= {m_acc[14:0], m_lfsr[15]}; m_cnt <= m_cnt + 1;
      end
      if (fail_force_i) m_ph <= 2;
      else if (m_ph == 0) begin
        if (m_tcnt == BIST - 1) m_ph <= 1;
        else m_tcnt <= m_tcnt + 1;
      end
    end
  end

  function automatic string tag_of(input logic v, input logic ill, input logic [31:0] d);
    if (!v) return "R7";
    if (ill) return "R8";
    case (d[31:30])
      2'b00: return "R2";
      2'b01: return "R6";
      2'b10: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: sample at negedge and compare with the model
  task automatic step();
    @(negedge clk_i);
    chk(tag_of(e_v, e_ill, e_d), {rvalid_o, illegal_o, rdata_o}, {e_v, e_ill, e_d});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; acc_i = 0; allow_i = 1; fail_force_i = 0;
    repeat (2) @(negedge clk_i);
    chk("R7 reset", {rvalid_o, illegal_o, rdata_o}, 34'd0);
    rst_ni = 1'b1;
  endtask

  task automatic rand_phase(input int n, input int fail_pct);
    for (int i = 0; i < n; i++) begin
      acc_i = ($urandom_range(0, 99) < 30);
      allow_i = ($urandom_range(0, 99) < 85);
      fail_force_i = ($urandom_range(0, 999) < fail_pct);
      step();
    end
    acc_i = 0; allow_i = 1; fail_force_i = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    do_reset();
    // R2: read every cycle across the self-test boundary
    acc_i = 1;
    for (int i = 0; i < BIST + 4; i++) begin
      step();
      if (i < BIST) chk("R2 self-test", {2'b00, rdata_o}, {2'b00, 2'b00, 30'd0});
      else          chk("R2 waiting", {2'b00, rdata_o}, {2'b00, 2'b01, 30'd0});
    end
    acc_i = 0;
    // R3: full after 16 gathered bits
    repeat (20) step();
    allow_i = 0; acc_i = 1; step();
    chk("R8 refused", {rvalid_o, illegal_o, rdata_o}, {1'b1, 1'b1, 32'd0});
    allow_i = 1; step();
    w = rdata_o;
    chk("R3 ready kept after refusal", {32'd0, rdata_o[31:30]}, {32'd0, 2'b10});
    step();
    chk("R6 consumed", {32'd0, rdata_o[31:30]}, {32'd0, 2'b01});
    acc_i = 0;
    // R6: refill exactly 16 cycles after consume
    repeat (14) step();
    acc_i = 1; step();
    chk("R6 refill pending", {32'd0, rdata_o[31:30]}, {32'd0, 2'b01});
    step();
    chk("R3 refilled", {32'd0, rdata_o[31:30]}, {32'd0, 2'b10});
    acc_i = 0;
    chk("R4 fresh data", {33'd0, rdata_o[15:0] != w[15:0]}, {33'd0, 1'b1});
    rand_phase(2000, 0);
    // R9: forced failure is sticky
    fail_force_i = 1; step(); fail_force_i = 0;
    acc_i = 1;
    for (int i = 0; i < 30; i++) begin
      step();
      chk("R9 dead", {2'b00, rdata_o}, {2'b00, 2'b11, 30'd0});
    end
    acc_i = 0;
    rand_phase(500, 0);
    do_reset();
    rand_phase(3000, 2);
    do_reset();
    rand_phase(1500, 0);
    done = 1;
    finish_run();
  end
endmodule